// File: doc/BRIEF.md
# Delta-Sigma Converter Result Reader

This block is the host-side engine that fetches conversion results from a delta-sigma converter running in externally clocked, single-cycle mode. A one-cycle request starts a read. The request carries an 11-bit channel and rate setting and selects how end of conversion is detected. In polled detection the block lowers chip select and watches the converter's data line until it reads 0. In flag detection it leaves chip select high and watches the converter's busy flag, and it lowers chip select only after that flag drops.

Once the converter is ready, the block issues exactly 32 serial clock periods. It shifts the setting out on the serial data output and captures the 32-bit result frame from the serial data input. It then raises chip select and reports either a sign-extended result with a one-cycle valid pulse or a frame-error pulse. When a read finishes, the converter begins its next conversion, so every read waits for end of conversion again. A wait that lasts too long ends with a timeout pulse.

Top module: `sd_adc_reader`

## Requirements
- R1: After reset, `cs_n_o` is 1, `sclk_o` is 0, and `valid_o`, `frame_err_o` and `timeout_o` are 0.
- R2: In polled mode (`wait_busy_i`=0 at request), `cs_n_o` goes low while waiting, and no serial clock edge occurs until `sdo_i` has been sampled at 0.
- R3: In flag mode (`wait_busy_i`=1 at request), `cs_n_o` stays high while `busy_i` is 1 and goes low only after `busy_i` has been sampled at 0.
- R4: A read issues exactly 32 rising edges on `sclk_o`. The serial clock idles low whenever chip select is high, and each high phase lasts HALF_PER system clocks.
- R5: `sdi_o` changes only while `sclk_o` is low. Across the 32 rising edges it presents 1, 0, then `cfg_i[10]` down to `cfg_i[0]`, then 0 for the remaining 19 bits.
- R6: `sdo_i` is sampled on each serial clock rise. The first sampled bit is frame bit 31 and the last is bit 0. `result_o` is frame bits 29..5 as a 25-bit two's-complement value, sign-extended to RES_W bits.
- R7: A good frame yields a single-cycle `valid_o`, with `cfg_o` equal to the setting sent in that frame.
- R8: If frame bit 31 or bit 30 is 1, `frame_err_o` pulses for one cycle and `valid_o` stays 0.
- R9: If end of conversion is not seen within TMO_CYC cycles of waiting, `timeout_o` pulses, chip select returns high, and no serial clock edge is produced.
- R10: A request made during a read is ignored. A request made after a read waits again for the next end of conversion before any clocking starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Start a read (accepted when idle) |
| cfg_i | input | 11 | Channel/rate setting, sent MSB first after the 1,0 preamble |
| wait_busy_i | input | 1 | 1: wait on busy flag; 0: poll data line |
| sdo_i | input | 1 | Converter serial data output |
| busy_i | input | 1 | Converter busy flag |
| cs_n_o | output | 1 | Converter chip select, active low |
| sclk_o | output | 1 | Serial clock, idles low |
| sdi_o | output | 1 | Serial data to converter |
| result_o | output | RES_W | Sign-extended conversion result |
| cfg_o | output | 11 | Setting used for the reported result |
| valid_o | output | 1 | One-cycle pulse: result good |
| frame_err_o | output | 1 | One-cycle pulse: header bits not 0 |
| timeout_o | output | 1 | One-cycle pulse: end-of-conversion wait expired |

## Verification
The case that is hardest to reach from the ports is a request that arrives just after a frame completes. At that moment the converter has already begun its next conversion, and a faulty controller would clock a stale frame without waiting. The bench models a converter that drops its ready state on the 32nd falling serial clock edge. It issues the follow-up request at once, holds the converter busy for a while, and confirms that chip select is low and no serial clock edge occurs. In a separate run, a second request is injected in the middle of a frame to show that it is discarded.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;
   localparam int FRAME_BITS = 32;
   localparam int CFG_BITS   = 11;
   localparam int DATA_BITS  = 25;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_XFER = 2'd2
   } rd_state_t;

   // Outgoing word: fixed 1,0 preamble, setting MSB first, zero fill.
   function automatic logic [FRAME_BITS-1:0] tx_word(input logic [CFG_BITS-1:0] c);
      return {2'b10, c, {(FRAME_BITS-2-CFG_BITS){1'b0}}};
   endfunction
endpackage

// File: rtl/adcrd_sclk_gen.sv
module adcrd_sclk_gen #(
   parameter int HALF_PER = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic sclk_o,
   output logic rise_o,
   output logic fall_o
);
   initial begin
      assert (HALF_PER >= 1) else $error("HALF_PER must be at least 1");
   end

   generate
      if (HALF_PER == 1) begin : g_fast
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      sclk_o <= 1'b0;
            else if (!run_i) sclk_o <= 1'b0;
            else             sclk_o <= ~sclk_o;
         end
         assign rise_o = run_i && !sclk_o;
         assign fall_o = run_i &&  sclk_o;
      end else begin : g_div
         localparam int CW = $clog2(HALF_PER);
         localparam logic [CW-1:0] RELOAD = CW'(HALF_PER - 1);
         logic [CW-1:0] cnt_q;
         logic          tick;

         assign tick = run_i && (cnt_q == '0);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q  <= RELOAD;
               sclk_o <= 1'b0;
            end else if (!run_i) begin
               cnt_q  <= RELOAD;
               sclk_o <= 1'b0;
            end else if (tick) begin
               cnt_q  <= RELOAD;
               sclk_o <= ~sclk_o;
            end else begin
               cnt_q  <= cnt_q - 1'b1;
            end
         end
         assign rise_o = tick && !sclk_o;
         assign fall_o = tick &&  sclk_o;
      end
   endgenerate

   // R4: the serial clock never rises while the generator is stopped
   p_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(run_i) |-> !sclk_o);
endmodule

// File: rtl/adcrd_frame.sv
module adcrd_frame
   import adcrd_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load_i,
   input  logic [CFG_BITS-1:0]  cfg_i,
   input  logic                 sclk_i,
   input  logic                 rise_i,
   input  logic                 fall_i,
   input  logic                 sdo_i,
   output logic                 sdi_o,
   output logic                 last_o,
   output logic [1:0]           hdr_o,
   output logic [DATA_BITS-1:0] data_o
);
   localparam int BW = $clog2(FRAME_BITS);

   logic [FRAME_BITS-1:0] tx_q;
   logic [FRAME_BITS-1:0] rx_q;
   logic [BW-1:0]         bit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q  <= '0;
         rx_q  <= '0;
         bit_q <= '0;
      end else begin
         if (load_i) begin
            tx_q  <= tx_word(cfg_i);
            bit_q <= '0;
         end else if (fall_i) begin
            tx_q  <= {tx_q[FRAME_BITS-2:0], 1'b0};
            bit_q <= bit_q + 1'b1;
         end
         if (rise_i) rx_q <= {rx_q[FRAME_BITS-2:0], sdo_i};
      end
   end

   assign sdi_o  = tx_q[FRAME_BITS-1];
   assign last_o = fall_i && (bit_q == BW'(FRAME_BITS - 1));
   assign hdr_o  = rx_q[FRAME_BITS-1 -: 2];
   assign data_o = rx_q[FRAME_BITS-3 -: DATA_BITS];

   // R5: data to the converter holds steady through each high phase
   p_sdi_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_i && $past(sclk_i)) |-> $stable(sdi_o));
endmodule

// File: rtl/adcrd_eoc_wait.sv
module adcrd_eoc_wait #(
   parameter int TMO_CYC = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active_i,
   input  logic use_busy_i,
   input  logic sdo_i,
   input  logic busy_i,
   output logic ready_o,
   output logic expire_o
);
   assign ready_o = active_i && (use_busy_i ? !busy_i : !sdo_i);

   generate
      if (TMO_CYC == 0) begin : g_no_tmo
         assign expire_o = 1'b0;
      end else begin : g_tmo
         localparam int TW = $clog2(TMO_CYC + 1);
         logic [TW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         cnt_q <= '0;
            else if (!active_i) cnt_q <= '0;
            else                cnt_q <= cnt_q + 1'b1;
         end
         assign expire_o = active_i && !ready_o && (cnt_q == TW'(TMO_CYC - 1));

         // R9: expiry only ever follows an uninterrupted waiting stretch
         p_expire_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
            expire_o |-> $past(active_i));
      end
   endgenerate
endmodule

// File: rtl/sd_adc_reader.sv
module sd_adc_reader
   import adcrd_pkg::*;
#(
   parameter int HALF_PER = 2,
   parameter int TMO_CYC  = 4096,
   parameter int RES_W    = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_i,
   input  logic [CFG_BITS-1:0] cfg_i,
   input  logic                wait_busy_i,
   input  logic                sdo_i,
   input  logic                busy_i,
   output logic                cs_n_o,
   output logic                sclk_o,
   output logic                sdi_o,
   output logic [RES_W-1:0]    result_o,
   output logic [CFG_BITS-1:0] cfg_o,
   output logic                valid_o,
   output logic                frame_err_o,
   output logic                timeout_o
);
   initial begin
      assert (RES_W >= DATA_BITS) else $error("RES_W narrower than result field");
   end

   rd_state_t           state_q;
   logic                mode_q;
   logic [CFG_BITS-1:0] cfg_q;
   logic                ready, expire, last, rise, fall;
   logic [1:0]          hdr;
   logic [DATA_BITS-1:0] data;
   logic signed [RES_W-1:0] ext;

   adcrd_eoc_wait #(.TMO_CYC(TMO_CYC)) u_wait (
      .clk(clk), .rst_n(rst_n),
      .active_i(state_q == ST_WAIT), .use_busy_i(mode_q),
      .sdo_i(sdo_i), .busy_i(busy_i),
      .ready_o(ready), .expire_o(expire)
   );

   adcrd_sclk_gen #(.HALF_PER(HALF_PER)) u_sclk (
      .clk(clk), .rst_n(rst_n), .run_i(state_q == ST_XFER),
      .sclk_o(sclk_o), .rise_o(rise), .fall_o(fall)
   );

   adcrd_frame u_frame (
      .clk(clk), .rst_n(rst_n),
      .load_i(ready), .cfg_i(cfg_q),
      .sclk_i(sclk_o), .rise_i(rise), .fall_i(fall), .sdo_i(sdo_i),
      .sdi_o(sdi_o), .last_o(last), .hdr_o(hdr), .data_o(data)
   );

   always_comb ext = RES_W'($signed(data));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         mode_q      <= 1'b0;
         cfg_q       <= '0;
         result_o    <= '0;
         cfg_o       <= '0;
         valid_o     <= 1'b0;
         frame_err_o <= 1'b0;
         timeout_o   <= 1'b0;
      end else begin
         valid_o     <= 1'b0;
         frame_err_o <= 1'b0;
         timeout_o   <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (req_i) begin
               cfg_q   <= cfg_i;
               mode_q  <= wait_busy_i;
               state_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (expire) begin
                  timeout_o <= 1'b1;
                  state_q   <= ST_IDLE;
               end else if (ready) begin
                  state_q <= ST_XFER;
               end
            end
            ST_XFER: if (last) begin
               state_q <= ST_IDLE;
               cfg_o   <= cfg_q;
               if (hdr != 2'b00) begin
                  frame_err_o <= 1'b1;
               end else begin
                  valid_o  <= 1'b1;
                  result_o <= ext;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign cs_n_o = !((state_q == ST_XFER) || (state_q == ST_WAIT && !mode_q));

   // R4: serial clock is low whenever the converter is deselected
   p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_o |-> !sclk_o);
   // R3: in flag mode chip select falls only after busy was seen low
   p_busy_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cs_n_o) && mode_q) |-> !$past(busy_i));
   // R2: polled mode leaves waiting only after the data line read 0
   p_poll_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_XFER && $past(state_q) == ST_WAIT && !mode_q) |-> !$past(sdo_i));
   // R8: at most one completion pulse at a time
   p_pulse_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({valid_o, frame_err_o, timeout_o}));
   // R7: valid lasts a single cycle
   p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);
endmodule

// File: tb/tb_sd_adc_reader.sv
module tb_sd_adc_reader;
   localparam int HALF = 2;
   localparam int TMO  = 300;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_i = 1'b0;
   logic [10:0] cfg_i = '0;
   logic        wait_busy_i = 1'b0;
   logic        sdo_i, busy_i;
   logic        cs_n_o, sclk_o, sdi_o;
   logic [31:0] result_o;
   logic [10:0] cfg_o;
   logic        valid_o, frame_err_o, timeout_o;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   sd_adc_reader #(.HALF_PER(HALF), .TMO_CYC(TMO), .RES_W(32)) dut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .cfg_i(cfg_i),
      .wait_busy_i(wait_busy_i), .sdo_i(sdo_i), .busy_i(busy_i),
      .cs_n_o(cs_n_o), .sclk_o(sclk_o), .sdi_o(sdi_o),
      .result_o(result_o), .cfg_o(cfg_o), .valid_o(valid_o),
      .frame_err_o(frame_err_o), .timeout_o(timeout_o)
   );

   // converter model
   logic [31:0] fr = '0;
   bit          eoc_ready = 1'b0;
   int          k = 0;
   int          rises = 0;
   int          hi_len = 0;
   int          hi_bad = 0;
   logic [31:0] sdi_cap = '0;

   assign busy_i = !eoc_ready;
   assign sdo_i  = cs_n_o ? 1'b1 : ((eoc_ready && k < 32) ? fr[31 - k] : 1'b1);

   always @(negedge sclk_o) begin
      k = k + 1;
      if (k == 32) eoc_ready = 1'b0;
      if (hi_len != HALF) hi_bad = hi_bad + 1;
      hi_len = 0;
   end
   always @(posedge cs_n_o) k = 0;
   always @(posedge sclk_o) begin
      rises = rises + 1;
      sdi_cap = {sdi_cap[30:0], sdi_o};
   end
   always @(negedge clk) if (sclk_o) hi_len = hi_len + 1;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_res(input logic [31:0] f);
      return {{7{f[29]}}, f[29:5]};
   endfunction

   task automatic clear_mon();
      rises = 0; hi_bad = 0; sdi_cap = '0;
   endtask

   task automatic request(input bit mode, input logic [10:0] c);
      @(negedge clk);
      req_i = 1'b1; cfg_i = c; wait_busy_i = mode;
      @(negedge clk);
      req_i = 1'b0;
   endtask

   task automatic wait_end(input int lim, output bit v, output bit e, output bit t,
                           output logic [31:0] res, output logic [10:0] c);
      v = 0; e = 0; t = 0; res = '0; c = '0;
      for (int i = 0; i < lim; i++) begin
         @(negedge clk);
         if (valid_o || frame_err_o || timeout_o) begin
            v = valid_o; e = frame_err_o; t = timeout_o; res = result_o; c = cfg_o;
            break;
         end
      end
   endtask

   task automatic t_reset();
      chk(cs_n_o == 1'b1, "R1 cs_n", cs_n_o, 1);
      chk(sclk_o == 1'b0, "R1 sclk", sclk_o, 0);
      chk({valid_o, frame_err_o, timeout_o} == 3'b000, "R1 pulses",
          {valid_o, frame_err_o, timeout_o}, 0);
   endtask

   task automatic t_read(input bit mode, input logic [31:0] f, input logic [10:0] c, input int pre);
      bit v, e, t; logic [31:0] res; logic [10:0] co;
      clear_mon(); fr = f; eoc_ready = 1'b0;
      request(mode, c);
      repeat (pre) @(negedge clk);
      if (mode) chk(cs_n_o == 1'b1, "R3 cs high while busy", cs_n_o, 1);
      else      chk(cs_n_o == 1'b0, "R2 cs low while polling", cs_n_o, 0);
      chk(rises == 0, "R2 no clock before ready", rises, 0);
      eoc_ready = 1'b1;
      wait_end(400, v, e, t, res, co);
      chk(v && !e && !t, "R7 valid", {v, e, t}, 3'b100);
      chk(res == exp_res(f), "R6 result", res, exp_res(f));
      chk(co == c, "R7 cfg_o", co, c);
      chk(rises == 32, "R4 rise count", rises, 32);
      chk(hi_bad == 0, "R4 high phase length", hi_bad, 0);
      chk(sdi_cap == {2'b10, c, 19'b0}, "R5 sdi stream", sdi_cap, {2'b10, c, 19'b0});
      @(negedge clk);
      chk(cs_n_o == 1'b1 && sclk_o == 1'b0, "R4 idle after frame", {cs_n_o, sclk_o}, 2'b10);
   endtask

   task automatic t_bad(input bit mode, input logic [31:0] f, input string tag);
      bit v, e, t; logic [31:0] res; logic [10:0] co;
      clear_mon(); fr = f; eoc_ready = 1'b1;
      request(mode, 11'h155);
      wait_end(400, v, e, t, res, co);
      chk(e && !v, tag, {v, e}, 2'b01);
   endtask

   task automatic t_timeout(input bit mode);
      bit v, e, t; logic [31:0] res; logic [10:0] co;
      clear_mon(); eoc_ready = 1'b0;
      request(mode, 11'h0F0);
      wait_end(TMO + 50, v, e, t, res, co);
      chk(t && !v && !e, "R9 timeout pulse", {v, e, t}, 3'b001);
      chk(rises == 0, "R9 no clocking", rises, 0);
      @(negedge clk);
      chk(cs_n_o == 1'b1, "R9 cs released", cs_n_o, 1);
   endtask

   task automatic t_r10();
      bit v, e, t; logic [31:0] res; logic [10:0] co;
      clear_mon(); fr = 32'h0ACE_1360; eoc_ready = 1'b1;
      request(1'b0, 11'h3A5);
      repeat (40) @(negedge clk);
      request(1'b1, 11'h05A);
      wait_end(400, v, e, t, res, co);
      chk(v && co == 11'h3A5, "R10 mid-frame request ignored", co, 11'h3A5);
      chk(rises == 32, "R10 single frame", rises, 32);
      // converter restarted; a new request must wait again
      clear_mon(); fr = 32'h3000_0040;
      request(1'b0, 11'h05A);
      repeat (30) @(negedge clk);
      chk(rises == 0 && cs_n_o == 1'b0, "R10 waits for next conversion", rises, 0);
      eoc_ready = 1'b1;
      wait_end(400, v, e, t, res, co);
      chk(v && res == exp_res(32'h3000_0040), "R10 second read", res, exp_res(32'h3000_0040));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_read(1'b0, 32'h1234_5678, 11'h7FF, 10);   // positive, polled
      t_read(1'b1, 32'h3F00_00A0, 11'h2AB, 15);   // negative, flag mode
      t_read(1'b0, 32'h2000_0000, 11'h000, 0);    // most negative
      t_read(1'b1, 32'h1FFF_FFE0, 11'h401, 3);    // most positive
      t_bad(1'b1, 32'h8000_1234, "R8 bit31 set");
      t_bad(1'b0, 32'h4000_1234, "R8 bit30 set");
      t_timeout(1'b0);
      t_timeout(1'b1);
      t_r10();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule